// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Gated Result Register

This unit is the computing stage of a small 16-bit processor datapath. It receives two 16-bit operands and a 5-bit operation code, forms one of fourteen results combinationally, and captures that result in an output register. Arithmetic covers wrap-around addition and subtraction with a separate carry/borrow flag. The logic group covers pass-through, bitwise operations, a boolean AND of the two operands, and four reductions that fold operand A down to one bit.

The register loads only in cycles where the load enable is high. In every other cycle it keeps its contents, so the result and the flag do not toggle while the operand buses move. A controller drives the operands and the code, raises the load enable for one cycle, and reads the registered result and flag from the next cycle onward.

Top module: `opcalc_unit`

## Requirements
- R1: While the active-low reset is low, the result register reads 0x0000 and the carry flag reads 0. Reset acts at once, without waiting for a clock edge.
- R2: On a rising clock edge with the load enable low, the result and the carry flag keep their previous values, whatever the operands and the code are.
- R3: Code 5'b00010 gives (A + B) mod 2^16. The flag is the carry out of bit 15.
- R4: Code 5'b00011 gives (A - B) mod 2^16. The flag is 1 exactly when A < B as unsigned numbers (a borrow).
- R5: Code 5'b00000 passes A through unchanged. Code 5'b00001 passes B through unchanged.
- R6: The bitwise codes are 5'b00100 A|B, 5'b00101 ~A, 5'b00110 A^B, 5'b00111 ~(A^B), and 5'b01000 A&B.
- R7: Code 5'b01001 gives a boolean AND. Bit 0 is 1 exactly when both A and B are nonzero, and bits 15:1 are 0.
- R8: The reductions of A are 5'b01010 AND, 5'b01011 OR, 5'b01100 XOR and 5'b01101 XNOR. Each places its bit at bit 0 and sets bits 15:1 to 0.
- R9: The unused codes 5'b01110 through 5'b11111 give a result of 0x0000 and a flag of 0.
- R10: Every code other than 5'b00010 and 5'b00011 loads the carry flag as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Load enable for the result register and the flag |
| opnd_a_i | input | 16 | Operand A |
| opnd_b_i | input | 16 | Operand B |
| op_sel_i | input | 5 | Operation code |
| result_o | output | 16 | Registered result |
| carry_o | output | 1 | Registered carry/borrow flag |

## Verification
The hardest condition to reach from the ports is a stored flag that the current code would overwrite. The stimulus loads a carry of 1 from a wrapping addition, then drops the load enable and switches to a logic code, which would load the flag as 0 if the register captured it. It checks that the flag and result stay put across several edges. It then raises the enable and checks that the flag clears. Every arithmetic boundary is driven directly: the wrap at 0xFFFF + 1, the borrow when A < B, and the equal-operand subtraction. The reductions each get one operand that makes the output bit 1 and one that makes it 0.

// File: rtl/opcalc_pkg.sv
package opcalc_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_PASSA = 5'd0,
    OP_PASSB = 5'd1,
    OP_ADD   = 5'd2,
    OP_SUB   = 5'd3,
    OP_OR    = 5'd4,
    OP_NOTA  = 5'd5,
    OP_XOR   = 5'd6,
    OP_XNOR  = 5'd7,
    OP_AND   = 5'd8,
    OP_LAND  = 5'd9,
    OP_RAND  = 5'd10,
    OP_ROR   = 5'd11,
    OP_RXOR  = 5'd12,
    OP_RXNOR = 5'd13
  } op_e;

  localparam logic [OPW-1:0] OP_FIRST_UNUSED = 5'd14;
endpackage

// File: rtl/opcalc_addsub.sv
module opcalc_addsub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          carry_o
);
  localparam int EW = DW + 1;

  function automatic logic [EW-1:0] add_ext(input logic [DW-1:0] x,
                                            input logic [DW-1:0] y,
                                            input logic          cin);
    return {1'b0, x} + {1'b0, y} + {{(EW-1){1'b0}}, cin};
  endfunction

  logic [DW-1:0] b_eff;
  logic [EW-1:0] wide;

  assign b_eff   = sub_i ? ~b_i : b_i;
  assign wide    = add_ext(a_i, b_eff, sub_i);
  assign sum_o   = wide[DW-1:0];
  // subtraction: carry out of A + ~B + 1 is "no borrow", so invert it
  assign carry_o = sub_i ? ~wide[DW] : wide[DW];

  always_comb begin
    if (!sub_i) begin
      assert_add_carry_R3: assert (carry_o == (sum_o < a_i))
        else $error("add carry disagrees with wrap");
    end else begin
      assert_sub_borrow_R4: assert (carry_o == (a_i < b_i))
        else $error("sub borrow disagrees with compare");
    end
  end
endmodule

// File: rtl/opcalc_bitlogic.sv
module opcalc_bitlogic
  import opcalc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [OPW-1:0] op_i,
  output logic [DW-1:0]  res_o
);
  localparam int UW = DW - 1;

  logic [DW-1:0] or_v, xor_v, and_v;

  for (genvar k = 0; k < DW; k++) begin : g_bit
    assign or_v[k]  = a_i[k] | b_i[k];
    assign xor_v[k] = a_i[k] ^ b_i[k];
    assign and_v[k] = a_i[k] & b_i[k];
  end

  function automatic logic fold_and(input logic [DW-1:0] v);
    return &v;
  endfunction
  function automatic logic fold_or(input logic [DW-1:0] v);
    return |v;
  endfunction
  function automatic logic fold_xor(input logic [DW-1:0] v);
    return ^v;
  endfunction
  function automatic logic [DW-1:0] widen(input logic bit0);
    return {{UW{1'b0}}, bit0};
  endfunction

  logic bool_and;
  logic narrow_op;

  assign bool_and  = fold_or(a_i) && fold_or(b_i);
  assign narrow_op = (op_i >= OP_LAND) && (op_i <= OP_RXNOR);

  always_comb begin
    case (op_i)
      OP_PASSA: res_o = a_i;
      OP_PASSB: res_o = b_i;
      OP_OR:    res_o = or_v;
      OP_NOTA:  res_o = ~a_i;
      OP_XOR:   res_o = xor_v;
      OP_XNOR:  res_o = ~xor_v;
      OP_AND:   res_o = and_v;
      OP_LAND:  res_o = widen(bool_and);
      OP_RAND:  res_o = widen(fold_and(a_i));
      OP_ROR:   res_o = widen(fold_or(a_i));
      OP_RXOR:  res_o = widen(fold_xor(a_i));
      OP_RXNOR: res_o = widen(~fold_xor(a_i));
      default:  res_o = '0;
    endcase
  end

  // R7 and R8: single-bit answers never spill above bit 0
  always_comb begin
    if (narrow_op) begin
      assert_narrow_R8: assert (res_o[DW-1:1] == '0)
        else $error("narrow result has upper bits set");
    end
  end
endmodule

// File: rtl/opcalc_resreg.sv
module opcalc_resreg #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_en_i,
  input  logic [DW-1:0] res_d,
  input  logic          cy_d,
  output logic [DW-1:0] res_q,
  output logic          cy_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      cy_q  <= 1'b0;
    end else if (ld_en_i) begin
      res_q <= res_d;
      cy_q  <= cy_d;
    end
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_en_i |=> ($stable(res_q) && $stable(cy_q)))
    else $error("register changed with load enable low");

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i |=> (res_q == $past(res_d) && cy_q == $past(cy_d)))
    else $error("register missed an enabled load");

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R1: assert (res_q == '0 && cy_q == 1'b0)
        else $error("register not cleared in reset");
    end
  end
endmodule

// File: rtl/opcalc_unit.sv
module opcalc_unit
  import opcalc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_en_i,
  input  logic [DW-1:0]  opnd_a_i,
  input  logic [DW-1:0]  opnd_b_i,
  input  logic [OPW-1:0] op_sel_i,
  output logic [DW-1:0]  result_o,
  output logic           carry_o
);
  logic          is_arith;
  logic          is_sub;
  logic [DW-1:0] arith_sum;
  logic          arith_cy;
  logic [DW-1:0] logic_res;
  logic [DW-1:0] nxt_res;
  logic          nxt_cy;

  assign is_arith = (op_sel_i == OP_ADD) || (op_sel_i == OP_SUB);
  assign is_sub   = (op_sel_i == OP_SUB);

  opcalc_addsub #(.DW(DW)) u_addsub (
    .a_i     (opnd_a_i),
    .b_i     (opnd_b_i),
    .sub_i   (is_sub),
    .sum_o   (arith_sum),
    .carry_o (arith_cy)
  );

  opcalc_bitlogic #(.DW(DW)) u_logic (
    .a_i   (opnd_a_i),
    .b_i   (opnd_b_i),
    .op_i  (op_sel_i),
    .res_o (logic_res)
  );

  assign nxt_res = is_arith ? arith_sum : logic_res;
  assign nxt_cy  = is_arith & arith_cy;

  opcalc_resreg #(.DW(DW)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_en_i (ld_en_i),
    .res_d   (nxt_res),
    .cy_d    (nxt_cy),
    .res_q   (result_o),
    .cy_q    (carry_o)
  );

  always_comb begin
    if (op_sel_i >= OP_FIRST_UNUSED) begin
      assert_unused_zero_R9: assert (nxt_res == '0 && nxt_cy == 1'b0)
        else $error("unused code gave nonzero output");
    end
  end

  assert_cy_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_en_i && !is_arith) |=> !carry_o)
    else $error("flag set by a non-arithmetic code");
endmodule

// File: tb/tb_opcalc_unit.sv
`timescale 1ns/1ps
module tb_opcalc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [4:0]  op = '0;
  logic [15:0] res;
  logic        cy;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  opcalc_unit dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .ld_en_i  (ld_en),
    .opnd_a_i (a),
    .opnd_b_i (b),
    .op_sel_i (op),
    .result_o (res),
    .carry_o  (cy)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] exp;
    logic        cy;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{5'd2,  16'h1234, 16'h0001, 16'h1235, 1'b0, 4'd3},  // R3 plain add
    '{5'd2,  16'hFFFF, 16'h0001, 16'h0000, 1'b1, 4'd3},  // R3 wrap
    '{5'd2,  16'h8000, 16'h8000, 16'h0000, 1'b1, 4'd3},  // R3 top bits
    '{5'd3,  16'h0005, 16'h0003, 16'h0002, 1'b0, 4'd4},  // R4
    '{5'd3,  16'h0003, 16'h0005, 16'hFFFE, 1'b1, 4'd4},  // R4 borrow
    '{5'd3,  16'h1234, 16'h1234, 16'h0000, 1'b0, 4'd4},  // R4 equal
    '{5'd0,  16'hABCD, 16'h1111, 16'hABCD, 1'b0, 4'd5},  // R5 pass A
    '{5'd1,  16'hABCD, 16'h1111, 16'h1111, 1'b0, 4'd5},  // R5 pass B
    '{5'd4,  16'hF0F0, 16'h0FF0, 16'hFFF0, 1'b0, 4'd6},  // R6 or
    '{5'd5,  16'h00FF, 16'h1234, 16'hFF00, 1'b0, 4'd6},  // R6 not
    '{5'd6,  16'hF0F0, 16'h0FF0, 16'hFF00, 1'b0, 4'd6},  // R6 xor
    '{5'd7,  16'hF0F0, 16'h0FF0, 16'h00FF, 1'b0, 4'd6},  // R6 xnor
    '{5'd8,  16'hF0F0, 16'h0FF0, 16'h00F0, 1'b0, 4'd6},  // R6 and
    '{5'd9,  16'h0100, 16'h8000, 16'h0001, 1'b0, 4'd7},  // R7 both nonzero
    '{5'd9,  16'h0000, 16'hFFFF, 16'h0000, 1'b0, 4'd7},  // R7 A zero
    '{5'd10, 16'hFFFF, 16'h0000, 16'h0001, 1'b0, 4'd8},  // R8 and-reduce
    '{5'd10, 16'hFFFE, 16'h0000, 16'h0000, 1'b0, 4'd8},
    '{5'd11, 16'h0000, 16'hFFFF, 16'h0000, 1'b0, 4'd8},  // R8 or-reduce
    '{5'd11, 16'h0400, 16'h0000, 16'h0001, 1'b0, 4'd8},
    '{5'd12, 16'h0007, 16'h0000, 16'h0001, 1'b0, 4'd8},  // R8 xor-reduce
    '{5'd12, 16'h0003, 16'h0000, 16'h0000, 1'b0, 4'd8},
    '{5'd13, 16'h0007, 16'h0000, 16'h0000, 1'b0, 4'd8},  // R8 xnor-reduce
    '{5'd13, 16'h0000, 16'h0000, 16'h0001, 1'b0, 4'd8},
    '{5'd14, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 4'd9},  // R9 first unused
    '{5'd31, 16'hFFFF, 16'h0001, 16'h0000, 1'b0, 4'd9},  // R9 last unused
    '{5'd2,  16'h7FFF, 16'h7FFF, 16'hFFFE, 1'b0, 4'd3}   // R3 no carry
  };

  task automatic check(input string tag, input logic [15:0] got_r, input logic [15:0] exp_r,
                       input logic got_c, input logic exp_c);
    total++;
    if (got_r !== exp_r || got_c !== exp_c) begin
      bad++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               tag, got_r, got_c, exp_r, exp_c);
    end
  endtask

  task automatic load(input logic [4:0] o, input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    op = o; a = x; b = y; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", res, 16'h0000, cy, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", res, 16'h0000, cy, 1'b0);

    for (int i = 0; i < NV; i++) begin
      load(VECS[i].op, VECS[i].a, VECS[i].b);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), res, VECS[i].exp, cy, VECS[i].cy);
    end

    // R2: hold result while inputs change with enable low
    load(5'd4, 16'hF0F0, 16'h0FF0);
    op = 5'd2; a = 16'hFFFF; b = 16'h0001;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2 hold result", res, 16'hFFF0, cy, 1'b0);
    end

    // R2: hold a set flag while a logic code is presented
    load(5'd2, 16'hFFFF, 16'h0001);
    check("R3 carry loaded", res, 16'h0000, cy, 1'b1);
    op = 5'd4; a = 16'h00F0; b = 16'h0F00;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2 hold flag", res, 16'h0000, cy, 1'b1);
    end

    // R10: enabled logic code clears the flag
    load(5'd4, 16'h00F0, 16'h0F00);
    check("R10 flag cleared", res, 16'h0FF0, cy, 1'b0);
    load(5'd3, 16'h0000, 16'h0001);
    check("R4 borrow set", res, 16'hFFFF, cy, 1'b1);
    load(5'd12, 16'h0001, 16'h0000);
    check("R10 flag cleared by reduction", res, 16'h0001, cy, 1'b0);

    // R1: asynchronous reset mid-run
    load(5'd0, 16'hABCD, 16'h0000);
    #1 rst_n = 1'b0;
    #1 check("R1 async clear", res, 16'h0000, cy, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stays clear", res, 16'h0000, cy, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule